// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address that a synchronous burst memory array uses on each cycle. An external address is captured when either of two start strobes is raised. One strobe comes from the processor and one from the cache controller. On each later cycle where the advance input is high, the block steps the two low address bits to the next beat of a four-beat burst. The upper address bits do not change until the next load.

A static order input selects the beat order. In linear order the low bits count up from the loaded value and wrap modulo four. In interleaved order the low bits are the loaded low bits XOR a beat counter. The order input is not registered, so a change reaches the output address without waiting for a clock edge.

Three chip enables are captured together with the address. Taken together, they decide whether the burst selects this device. The processor strobe only acts while the primary active-low enable is asserted. The controller strobe always acts.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `mem_addr` is all zeros and `burst_sel` is 0.
- R2: When `strobe_ctl` is 1 at a rising clock edge, `mem_addr` equals `addr_in` from the next cycle on, whatever the chip enables are.
- R3: When `strobe_cpu` is 1 and `strobe_ctl` is 0, the address is loaded only if `ce_n` is 0. If `ce_n` is 1, `mem_addr` and `burst_sel` keep their values.
- R4: At each load, `burst_sel` becomes 1 exactly when `ce_n`=0, `ce_hi`=1 and `ce_lo_n`=0. Between loads, `burst_sel` keeps its value.
- R5: With no strobe and `advance`=0, `mem_addr` does not change.
- R6: With `order_sel`=0 (linear), the low two bits after k advances equal (loaded low bits + k) mod 4.
- R7: With `order_sel`=1 (interleaved), the low two bits after k advances equal the loaded low bits XOR (k mod 4).
- R8: A strobe in the same cycle as `advance` loads the new address at beat 0, and the advance is dropped.
- R9: After the fourth beat, the next advance returns to the first beat (the loaded low bits).
- R10: Bits above the low two come from the loaded address and change only on a load.
- R11: A change of `order_sel` shows on `mem_addr` at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_in | input | ADDR_W | External start address |
| strobe_cpu | input | 1 | Processor start strobe, gated by `ce_n` |
| strobe_ctl | input | 1 | Controller start strobe, always loads |
| advance | input | 1 | Step to the next beat |
| ce_n | input | 1 | Primary chip enable, active low |
| ce_hi | input | 1 | Depth-expansion enable, active high |
| ce_lo_n | input | 1 | Depth-expansion enable, active low |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| mem_addr | output | ADDR_W | Current array word address |
| burst_sel | output | 1 | The captured enables select this device |

## Verification
Both orders are run from every one of the four start offsets, through eight advances, so the wrap back to the first beat is seen. Linear and interleaved sequences differ only for odd start offsets, so the full sweep is what separates the two formulas.

Idle cycles are placed between advances to show that the address holds. A strobe is raised together with an advance to show that the new load takes priority.

The two strobes are tried under each enable pattern. This shows apart the processor strobe being ignored, a load that is not selected, and a load that is selected. Finally, `order_sel` is flipped in the middle of a burst, between clock edges, to show that it acts without a clock.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef logic [7:0] beat_t;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;

  // Offset of beat `cnt` from start offset `lo`, kept to `w` bits.
  function automatic beat_t order_offset(beat_t lo, beat_t cnt, order_e ord, int unsigned w);
    beat_t mask;
    mask = beat_t'((1 << w) - 1);
    if (ord == ORDER_INTERLEAVE) return (lo ^ cnt) & mask;
    return beat_t'(lo + cnt) & mask;
  endfunction
endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              ce_n,
  input  logic              ce_hi,
  input  logic              ce_lo_n,
  output logic              load_evt,
  output logic [ADDR_W-1:0] base_q,
  output logic              sel_q
);
  logic cpu_ok;
  logic sel_now;

  assign cpu_ok   = strobe_cpu & ~ce_n;
  assign load_evt = strobe_ctl | cpu_ok;
  assign sel_now  = ~ce_n & ce_hi & ~ce_lo_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      sel_q  <= 1'b0;
    end else if (load_evt) begin
      base_q <= addr_in;
      sel_q  <= sel_now;
    end
  end

  assert_cpu_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_cpu && ce_n && !strobe_ctl) |=> ($stable(base_q) && $stable(sel_q)));

  assert_ctl_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_ctl |=> (base_q == $past(addr_in)));

  assert_sel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(sel_q));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic              advance,
  output logic [BEAT_W-1:0] beat_q
);
  logic step_evt;
  assign step_evt = advance & ~load_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        beat_q <= '0;
    else if (load_evt) beat_q <= '0;
    else if (step_evt) beat_q <= beat_q + 1'b1;
  end

  assert_load_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (beat_q == '0));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !advance) |=> $stable(beat_q));

  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && (beat_q == '1)) |=> (beat_q == '0));
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic [ADDR_W-1:0] base_q,
  input  logic [BEAT_W-1:0] beat_q,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] mem_addr
);
  beat_t  off;
  order_e ord;

  always_comb begin
    ord = order_e'(order_sel);
    off = order_offset(beat_t'(base_q[BEAT_W-1:0]), beat_t'(beat_q), ord, BEAT_W);
    mem_addr = {base_q[ADDR_W-1:BEAT_W], off[BEAT_W-1:0]};
  end

  // R6: at beat 0 both orders give back the loaded offset
  always_comb begin
    if (beat_q == '0)
      assert_beat0_R6: assert (mem_addr == base_q);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              advance,
  input  logic              ce_n,
  input  logic              ce_hi,
  input  logic              ce_lo_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              burst_sel
);
  logic              load_evt;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;

  burst_load_ctrl #(.ADDR_W(ADDR_W)) load_i (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
    .ce_n(ce_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
    .load_evt(load_evt), .base_q(base_q), .sel_q(burst_sel)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) beat_i (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt),
    .advance(advance), .beat_q(beat_q)
  );

  burst_addr_map #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) map_i (
    .base_q(base_q), .beat_q(beat_q), .order_sel(order_sel), .mem_addr(mem_addr)
  );

  assert_upper_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(mem_addr[ADDR_W-1:BEAT_W]));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (mem_addr == '0 && !burst_sel));
endmodule

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;
  localparam int AW = 18;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr_in = '0;
  logic strobe_cpu = 0, strobe_ctl = 0, advance = 0;
  logic ce_n = 1, ce_hi = 0, ce_lo_n = 1, order_sel = 0;
  logic [AW-1:0] mem_addr;
  logic burst_sel;

  int checks = 0, fails = 0;
  bit done = 0;

  // Model state, taken from the requirements
  int unsigned m_base = 0, m_beat = 0;
  bit m_sel = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strobe_cpu(strobe_cpu),
    .strobe_ctl(strobe_ctl), .advance(advance), .ce_n(ce_n), .ce_hi(ce_hi),
    .ce_lo_n(ce_lo_n), .order_sel(order_sel), .mem_addr(mem_addr), .burst_sel(burst_sel)
  );

  function automatic int unsigned exp_addr(int unsigned base, int unsigned k, bit ilv);
    int unsigned lo;
    lo = ilv ? ((base % 4) ^ (k % 4)) : (((base % 4) + k) % 4);
    return (base - (base % 4)) + lo;
  endfunction

  task automatic check(string tag);
    int unsigned e;
    e = exp_addr(m_base, m_beat, order_sel);
    checks++;
    if (mem_addr !== AW'(e)) begin
      fails++;
      $display("FAIL %s mem_addr got %h exp %h", tag, mem_addr, AW'(e));
    end
    checks++;
    if (burst_sel !== m_sel) begin
      fails++;
      $display("FAIL %s burst_sel got %0d exp %0d", tag, burst_sel, m_sel);
    end
  endtask

  // Called at a falling edge: apply inputs, clock once, update model, check
  task automatic cycle(bit cpu, bit ctl, bit adv, bit cen, bit chi, bit clon,
                       int unsigned a, string tag);
    bit ld;
    strobe_cpu = cpu; strobe_ctl = ctl; advance = adv;
    ce_n = cen; ce_hi = chi; ce_lo_n = clon; addr_in = AW'(a);
    @(posedge clk);
    ld = ctl || (cpu && !cen);
    if (ld) begin
      m_base = a; m_beat = 0; m_sel = !cen && chi && !clon;
    end else if (adv) m_beat = (m_beat + 1) % 4;
    #1 check(tag);
    @(negedge clk);
    strobe_cpu = 0; strobe_ctl = 0; advance = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;
    @(negedge clk);
    check("R1");

    // R2: controller strobe loads while deselected
    cycle(0, 1, 0, 1, 0, 1, 'h2A5C1, "R2");
    // R3: processor strobe ignored with ce_n=1
    cycle(1, 0, 0, 1, 1, 0, 'h11113, "R3");
    // R3/R4: processor strobe with full select
    cycle(1, 0, 0, 0, 1, 0, 'h30002, "R4");
    // R4: processor loads but ce_hi low -> not selected
    cycle(1, 0, 0, 0, 0, 0, 'h00F01, "R4");
    // R4: ce_lo_n high -> not selected
    cycle(0, 1, 0, 0, 1, 1, 'h12345, "R4");
    cycle(0, 0, 0, 0, 1, 1, 0, "R4");

    // Sweep both orders and all start offsets, through a wrap
    for (int ilv = 0; ilv < 2; ilv++) begin
      order_sel = ilv[0];
      for (int off = 0; off < 4; off++) begin
        cycle(0, 1, 0, 0, 1, 0, 'h1F00 * (off + 1) + off, "R2");
        for (int k = 1; k <= 8; k++) begin
          cycle(0, 0, 1, 1, 0, 1, 0,
                (k == 4 || k == 8) ? "R9" : (ilv == 1 ? "R7" : "R6"));
          if (k == 2) cycle(0, 0, 0, 1, 0, 1, 0, "R5");
          if (k == 5) cycle(1, 0, 0, 1, 0, 1, 'h3FFFF, "R10");
        end
      end
    end

    // R8: strobe beats advance in the same cycle
    order_sel = 0;
    cycle(0, 1, 0, 0, 1, 0, 'h00401, "R2");
    cycle(0, 0, 1, 0, 1, 0, 0, "R6");
    cycle(0, 1, 1, 0, 1, 0, 'h2BEE2, "R8");
    cycle(1, 0, 1, 0, 1, 0, 'h00B03, "R8");

    // R11: order change mid-burst without a clock edge
    cycle(0, 0, 1, 0, 1, 0, 0, "R6");
    order_sel = 1;
    #0.5 check("R11");
    order_sel = 0;
    #0.5 check("R11");

    finish_run();
  end
endmodule